// File: doc/BRIEF.md
# Clamping Successive-Approximation Register

This block is the digital core of a 12-bit successive-approximation converter. After a start request it runs a binary search. Each clock it drives a trial code to an external DAC and reads back one comparator decision. The last decision yields a signed result in two's complement. The analog DAC, the comparator and the reference sit outside the block. The trial code on the DAC port is offset binary, so mid-scale is 0x800. The block forms the signed result by inverting the top bit of the settled trial code.

The input stage supplies two out-of-range flags. The block captures them in the same cycle it accepts a start request. If either flag was set, the block replaces the searched code with the matching full-scale code. Logic downstream therefore sees a saturated value and never a wrapped one. Once a conversion has been accepted it cannot be interrupted, and its result stays on the result port until the next conversion finishes.

Top module: `sarClampTop`

## Requirements
- R1: While reset is asserted and after it is released, busy and donePulse are 0, resultCode is 0x000 and trialCode is 0x000.
- R2: A startReq that is high at a clock edge while busy is 0 sets busy after that edge and puts the mid-scale trial 0x800 (offset binary, bit 11 set, all other bits clear) on trialCode.
- R3: One bit is resolved per clock, from bit 11 down to bit 0. A cmpBit of 1 (input at or above the trial level) keeps the bit under test, and a 0 clears it. In the same edge the next lower bit is set to 1. After the twelfth decision edge, trialCode holds the final offset-binary code.
- R4: busy stays high for exactly 13 cycles: 12 decision cycles and 1 latch cycle. donePulse is high for exactly the one cycle in which busy first reads 0 again.
- R5: Without range flags, resultCode equals the final trial code with bit 11 inverted (two's complement). For an input of v LSB the result is the code k with k-0.5 <= v < k+0.5, limited to -2048..2047. The 0x000 to 0x001 step lies at +0.5 LSB, the 0xFFF to 0x000 step at -0.5 LSB, and the 0x7FE to 0x7FF step at 2046.5 LSB.
- R6: If overRange was high in the cycle the start was accepted, the result is 0x7FF, whatever the comparator decided.
- R7: If underRange (and not overRange) was high in the cycle the start was accepted, the result is 0x800. When both flags are high, overRange wins and the result is 0x7FF.
- R8: overRange and underRange have no effect on a conversion while busy is high.
- R9: startReq while busy is high is ignored. The running conversion keeps its timing and result, and no new conversion follows it.
- R10: resultCode changes only in the cycle in which donePulse is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a conversion |
| cmpBit | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| overRange | input | 1 | Input above positive full scale, sampled when a start is accepted |
| underRange | input | 1 | Input below negative full scale, sampled when a start is accepted |
| trialCode | output | 12 | Offset-binary trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| donePulse | output | 1 | One-cycle pulse when a new result is on resultCode |
| resultCode | output | 12 | Two's-complement result |

## Verification
Some behaviours are checked on every cycle. These are the mid-scale trial after an accepted start, the exact 13-cycle length of busy, the single-cycle donePulse that coincides with busy falling, and a result that holds outside donePulse. The checks also cover saturation to the correct full-scale code whenever a flag was captured at the start, and the fact that a start during a conversion never lengthens busy.

Other behaviours need a model of the analog input, so only the bench scenarios can show them. These are the step-by-step trial sequence and the exact code at each ideal transition point near zero and at both ends of the range. The same holds for showing that flags and start requests arriving mid-conversion leave the result untouched.

// File: rtl/sarClampPkg.sv
package sarClampPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_LATCH = 2'd2
  } sarState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // accept start: seed trial, capture range flags
    logic decide;  // resolve the bit under test
    logic finish;  // form and register the result
  } sarStrobes_t;

endpackage

// File: rtl/sarClampCtrl.sv
module sarClampCtrl
  import sarClampPkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output sarStrobes_t strobes,
  output logic        busy
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  sarState_e       stateQ, stateD;
  logic [CNT_W-1:0] bitCntQ, bitCntD;

  always_comb begin
    stateD  = stateQ;
    bitCntD = bitCntQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strobes.load = 1'b1;
          stateD       = ST_CONV;
          bitCntD      = LAST_IDX;
        end
      end
      ST_CONV: begin
        strobes.decide = 1'b1;
        if (bitCntQ == '0) begin
          stateD = ST_LATCH;
        end else begin
          bitCntD = bitCntQ - 1'b1;
        end
      end
      ST_LATCH: begin
        strobes.finish = 1'b1;
        stateD         = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      bitCntQ <= '0;
    end else begin
      stateQ  <= stateD;
      bitCntQ <= bitCntD;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/sarClampDatapath.sv
module sarClampDatapath
  import sarClampPkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobes_t      strobes,
  input  logic             cmpBit,
  input  logic             overRange,
  input  logic             underRange,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultCode,
  output logic             donePulse
);

  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] POS_FS   = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_FS   = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialQ, trialNext;
  logic [WIDTH-1:0] maskQ;
  logic [WIDTH-1:0] resultQ;
  logic [WIDTH-1:0] signedCode;
  logic [WIDTH-1:0] finalCode;
  logic             overSeenQ, underSeenQ;
  logic             doneQ;

  // per-bit update: bit under test takes the decision, the next one is tried
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign trialNext[i] = maskQ[i] ? cmpBit : trialQ[i];
    end else begin : g_low
      assign trialNext[i] = maskQ[i]   ? cmpBit :
                            maskQ[i+1] ? 1'b1   : trialQ[i];
    end
  end

  assign signedCode = {~trialQ[WIDTH-1], trialQ[WIDTH-2:0]};

  always_comb begin
    if (overSeenQ) begin
      finalCode = POS_FS;
    end else if (underSeenQ) begin
      finalCode = NEG_FS;
    end else begin
      finalCode = signedCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialQ     <= '0;
      maskQ      <= '0;
      overSeenQ  <= 1'b0;
      underSeenQ <= 1'b0;
    end else if (strobes.load) begin
      trialQ     <= MID_CODE;
      maskQ      <= MID_CODE;
      overSeenQ  <= overRange;
      underSeenQ <= underRange;
    end else if (strobes.decide) begin
      trialQ <= trialNext;
      maskQ  <= maskQ >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobes.finish;
      if (strobes.finish) begin
        resultQ <= finalCode;
      end
    end
  end

  assign trialCode  = trialQ;
  assign resultCode = resultQ;
  assign donePulse  = doneQ;

endmodule

// File: rtl/sarClampTop.sv
module sarClampTop
  import sarClampPkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmpBit,
  input  logic             overRange,
  input  logic             underRange,
  output logic [WIDTH-1:0] trialCode,
  output logic             busy,
  output logic             donePulse,
  output logic [WIDTH-1:0] resultCode
);

  sarStrobes_t strobes;

  sarClampCtrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .strobes (strobes),
    .busy    (busy)
  );

  sarClampDatapath #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmpBit    (cmpBit),
    .overRange (overRange),
    .underRange(underRange),
    .trialCode (trialCode),
    .resultCode(resultCode),
    .donePulse (donePulse)
  );

endmodule

// File: rtl/sarClampChecker.sv
module sarClampChecker #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             overRange,
  input logic             underRange,
  input logic             busy,
  input logic             donePulse,
  input logic [WIDTH-1:0] trialCode,
  input logic [WIDTH-1:0] resultCode
);

  localparam int CW = $clog2(WIDTH + 3);
  localparam logic [CW-1:0] CONV_LEN = CW'(WIDTH + 1);
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] POS_FS   = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_FS   = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] busyCnt;
  logic          ovSeen, unSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      ovSeen  <= 1'b0;
      unSeen  <= 1'b0;
    end else begin
      if (busy) begin
        if (busyCnt != '1) busyCnt <= busyCnt + 1'b1;
      end else begin
        busyCnt <= '0;
      end
      if (startReq && !busy) begin
        ovSeen <= overRange;
        unSeen <= underRange;
      end
    end
  end

  a_r2_mid_trial: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && trialCode == MID_CODE));

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == CONV_LEN));

  a_r4_done_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePulse);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt <= CONV_LEN));

  a_r6_pos_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && ovSeen) |-> (resultCode == POS_FS));

  a_r7_neg_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && unSeen && !ovSeen) |-> (resultCode == NEG_FS));

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> $stable(resultCode));

endmodule

bind sarClampTop sarClampChecker #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .overRange (overRange),
  .underRange(underRange),
  .busy      (busy),
  .donePulse (donePulse),
  .trialCode (trialCode),
  .resultCode(resultCode)
);

// File: tb/sarClampTop_tb_top.sv
module sarClampTop_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        overRange = 1'b0;
  logic        underRange = 1'b0;
  logic        cmpBit;
  logic [11:0] trialCode;
  logic        busy;
  logic        donePulse;
  logic [11:0] resultCode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // analog input in half-LSB units
  int vHalf = 0;

  always #4 clk = ~clk;

  // ideal comparator: input at or above the trial level minus half an LSB
  assign cmpBit = (vHalf >= 2 * (int'({20'd0, trialCode}) - 2048) - 1);

  sarClampTop #(.WIDTH(12)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cmpBit    (cmpBit),
    .overRange (overRange),
    .underRange(underRange),
    .trialCode (trialCode),
    .busy      (busy),
    .donePulse (donePulse),
    .resultCode(resultCode)
  );

  task automatic doCheck(input bit ok, input string tag, input string what,
                         input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int modelCode(input int vh);
    int num, q;
    num = vh + 1;
    q = num / 2;
    if (num < 0 && (num % 2) != 0) q = q - 1;
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return q;
  endfunction

  function automatic int expTrial(input int off, input int k);
    int keep;
    if (k >= 12) return off;
    keep = (4095 << (12 - k)) & 4095;
    return (off & keep) | (1 << (11 - k));
  endfunction

  task automatic checkReset();
    @(negedge clk);
    doCheck(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    doCheck(donePulse == 1'b0, "R1", "done in reset", int'(donePulse), 0);
    doCheck(resultCode == 12'h000, "R1", "result in reset", int'(resultCode), 0);
    doCheck(trialCode == 12'h000, "R1", "trial in reset", int'(trialCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    doCheck(!busy && !donePulse && resultCode == 12'h000, "R1",
            "idle after reset", int'(resultCode), 0);
  endtask

  task automatic runConv(input int vh, input bit ov, input bit un,
                         input bit lateFlags, input bit lateStart, input string tag);
    int c, off, expRes, firstBad, badVal, badExp;
    bit seqOk;
    seqOk = 1'b1;
    firstBad = -1; badVal = 0; badExp = 0;
    vHalf = vh;
    c = modelCode(vh);
    off = (c + 2048) & 4095;
    expRes = ov ? 2047 : (un ? -2048 : c);
    expRes = expRes & 4095;
    @(negedge clk);
    startReq = 1'b1; overRange = ov; underRange = un;
    @(negedge clk);
    startReq = 1'b0; overRange = 1'b0; underRange = 1'b0;
    doCheck(busy == 1'b1 && trialCode == 12'h800, "R2", "mid-scale start",
            int'(trialCode), 'h800);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (trialCode != 12'(expTrial(off, k)) || !busy || donePulse) begin
        if (seqOk) begin
          firstBad = k; badVal = int'(trialCode); badExp = expTrial(off, k);
        end
        seqOk = 1'b0;
      end
      overRange  = lateFlags && (k >= 3) && (k <= 6);
      underRange = lateFlags && (k >= 3) && (k <= 6);
      startReq   = lateStart && (k == 5);
    end
    overRange = 1'b0; underRange = 1'b0; startReq = 1'b0;
    doCheck(seqOk, "R3", $sformatf("trial sequence step %0d", firstBad), badVal, badExp);
    @(negedge clk);
    doCheck(donePulse == 1'b1 && busy == 1'b0, "R4", "done with busy low after 13 cycles",
            int'({donePulse, busy}), 2);
    doCheck(resultCode == 12'(expRes), tag, $sformatf("result for vHalf=%0d", vh),
            int'(resultCode), expRes);
    @(negedge clk);
    doCheck(donePulse == 1'b0 && busy == 1'b0, "R4", "single done, no restart (R9)",
            int'({donePulse, busy}), 0);
    doCheck(resultCode == 12'(expRes), "R10", "result held after done",
            int'(resultCode), expRes);
  endtask

  task automatic holdTest();
    logic [11:0] held;
    bit ok;
    ok = 1'b1;
    held = resultCode;
    vHalf = -1234;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (resultCode != held || donePulse || busy) ok = 1'b0;
    end
    doCheck(ok, "R10", "result holds while idle", int'(resultCode), int'(held));
  endtask

  initial begin
    checkReset();
    runConv(0,     0, 0, 0, 0, "R5");
    runConv(1,     0, 0, 0, 0, "R5");
    runConv(-1,    0, 0, 0, 0, "R5");
    runConv(-2,    0, 0, 0, 0, "R5");
    runConv(4093,  0, 0, 0, 0, "R5");
    runConv(4092,  0, 0, 0, 0, "R5");
    runConv(-4095, 0, 0, 0, 0, "R5");
    runConv(-4096, 0, 0, 0, 0, "R5");
    runConv(2222,  0, 0, 0, 0, "R5");
    runConv(-3333, 0, 0, 0, 0, "R5");
    runConv(100,   1, 0, 0, 0, "R6");
    runConv(-50,   0, 1, 0, 0, "R7");
    runConv(10,    1, 1, 0, 0, "R7");
    runConv(37,    0, 0, 1, 0, "R8");
    runConv(555,   0, 0, 0, 1, "R9");
    holdTest();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule